// File: doc/BRIEF.md
# Saturating Branch Sample Recorder

This block records the source and target addresses of retired taken branches into a small bank of register pairs. Recording starts only once a sampling counter has overflowed. The bank fills in a single pass from the current write slot up to the last slot. At that point the recorder clears its own enable bit and freezes its contents, so a later reader sees exactly the branches that followed the overflow.

The overflow interrupt is not sent at once. It is held while the bank fills and is released one cycle after the last slot is written. It is also released one cycle after software clears the enable bit, whichever comes first. An overflow that arrives while recording is disabled is passed straight through.

Software reaches the block through a flat register port. Address 0 holds the configuration word. The entry pairs lie above it, and each entry register can also be written. This lets software plant a marker value, such as 0xFFFF_FFFF_FFFF_FFFE, in a target register to flag stale data.

Top module: `branch_sample_recorder`

## Requirements
- R1: After reset the configuration word reads 0x18, every entry register reads zero and the interrupt output is low.
- R2: Configuration word layout: bit 2 is the enable, bit 5 is the valid flag, bits 19:16 are the next-slot index and bits 26:24 are the counter select. Each of these fields reads back as last written. Bits 4:3 always read 11b, whatever is written to them, and every other bit reads zero.
- R3: Register map with the default depth of 16 and a 6-bit address. The configuration word is at address 0, the source of entry i is at 32+2i and the target of entry i is at 33+2i. Entry registers are readable and writable. Addresses 1 to 31 read zero and ignore writes.
- R4: A capture happens on a clock edge when four conditions hold: the enable is set, an overflow has armed the recorder, the branch strobe is high and no register write is present. A capture stores the source and target into the slot named by the index, increments the index and sets the valid flag.
- R5: Branch strobes change nothing while the enable is clear, or while the enable is set but no overflow has yet armed the recorder.
- R6: A capture into slot 15 returns the index to 0 and clears the enable. Later strobes leave every entry unchanged.
- R7: Recording starts at whatever index software wrote. From a start index of k, exactly 16-k captures fill the bank.
- R8: An overflow that arrives while enabled is held. The interrupt pulses high for one cycle, in the cycle after the capture that fills slot 15.
- R9: A configuration write that clears the enable while an interrupt is held gives a one-cycle interrupt pulse in the next cycle. Writing back the index and valid values keeps them as they were.
- R10: An overflow that arrives while the enable is clear gives a one-cycle interrupt pulse in the next cycle and does not arm the recorder.
- R11: A register write in a given cycle suppresses a capture in that cycle.
- R12: The valid flag is set by the first capture. It is cleared only by a configuration write with bit 5 low, and writing an all-zero word clears both the index and the valid flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| brTaken | input | 1 | Retired taken-branch strobe |
| brFrom | input | 64 | Branch source address |
| brTo | input | 64 | Branch target address |
| ctrOverflow | input | 1 | Sampling counter overflow pulse |
| regAddr | input | 6 | Register address for reads and writes |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 64 | Register write data |
| regRdData | output | 64 | Combinational read data for regAddr |
| irqOut | output | 1 | Interrupt pulse |

## Verification
The hardest state to reach from the ports is a held interrupt that several events then try to release in the same or neighbouring cycles. Examples are a saturating capture that lands next to a new overflow, or a configuration write that drops the enable in the same cycle an overflow arrives. Directed sequences first write a nonzero start index and arm the recorder. They then fill the bank or clear the enable part-way. A long random phase mixes overflows, strobes, entry writes and configuration writes, so these collisions recur against the cycle-level model.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  localparam int EN_BIT    = 2;
  localparam int RSV_LSB   = 3;
  localparam int VALID_BIT = 5;
  localparam int IDX_LSB   = 16;
  localparam int SEL_LSB   = 24;
  localparam int SEL_W     = 3;

  typedef struct packed {
    logic capture;
    logic hostWrite;
  } dpStrobe_t;
endpackage

// File: rtl/bsr_ctrl.sv
module bsr_ctrl
  import bsr_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int AW     = 6,
  parameter int DATA_W = 64,
  localparam int IW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              brTaken,
  input  logic              ctrOverflow,
  input  logic              regWrEn,
  input  logic [AW-1:0]     regAddr,
  input  logic              wrEnable,
  input  logic              wrValid,
  input  logic [IW-1:0]     wrIdx,
  input  logic [SEL_W-1:0]  wrSel,
  output dpStrobe_t         strobe,
  output logic [IW-1:0]     slot,
  output logic [DATA_W-1:0] cfgWord,
  output logic              irqOut
);
  logic             enQ, validQ, armedQ, irqQ;
  logic [IW-1:0]    idxQ;
  logic [SEL_W-1:0] selQ;
  logic             cfgWr, capture, lastSlot, heldNow, enNext, irqNext;

  assign cfgWr    = regWrEn && (regAddr == '0);
  assign capture  = enQ && armedQ && brTaken && !regWrEn;
  assign lastSlot = (idxQ == IW'(DEPTH - 1));
  assign heldNow  = armedQ || (ctrOverflow && enQ);

  always_comb begin
    if (cfgWr)                    enNext = wrEnable;
    else if (capture && lastSlot) enNext = 1'b0;
    else                          enNext = enQ;
  end

  assign irqNext = (ctrOverflow && !enQ) || (heldNow && !enNext);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ    <= 1'b0;
      validQ <= 1'b0;
      armedQ <= 1'b0;
      irqQ   <= 1'b0;
      idxQ   <= '0;
      selQ   <= '0;
    end else begin
      enQ    <= enNext;
      armedQ <= heldNow && enNext;
      irqQ   <= irqNext;
      if (cfgWr) begin
        validQ <= wrValid;
        idxQ   <= wrIdx;
        selQ   <= wrSel;
      end else if (capture) begin
        validQ <= 1'b1;
        idxQ   <= lastSlot ? '0 : idxQ + 1'b1;
      end
    end
  end

  always_comb begin
    cfgWord                   = '0;
    cfgWord[EN_BIT]           = enQ;
    cfgWord[RSV_LSB +: 2]     = 2'b11;
    cfgWord[VALID_BIT]        = validQ;
    cfgWord[IDX_LSB +: IW]    = idxQ;
    cfgWord[SEL_LSB +: SEL_W] = selQ;
  end

  assign strobe.capture   = capture;
  assign strobe.hostWrite = regWrEn;
  assign slot             = idxQ;
  assign irqOut           = irqQ;

  // R6: filling the last slot stops recording and wraps the index
  a_r6_saturate_stop: assert property (@(posedge clk) disable iff (!rstN)
    (capture && lastSlot) |=> (!enQ && idxQ == '0));
  // R8: a held interrupt never survives a cleared enable
  a_r8_armed_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    armedQ |-> enQ);
  // R12: valid only drops through a configuration write
  a_r12_valid_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (validQ && !cfgWr) |=> validQ);
  // R9: index moves only on a capture or a configuration write
  a_r9_idx_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgWr && !capture) |=> $stable(idxQ));
  // R10: every interrupt traces back to an overflow or a held state
  a_r10_irq_cause: assert property (@(posedge clk) disable iff (!rstN)
    irqQ |-> $past(ctrOverflow || armedQ));
endmodule

// File: rtl/bsr_datapath.sv
module bsr_datapath
  import bsr_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int AW     = 6,
  parameter int DATA_W = 64,
  localparam int IW       = $clog2(DEPTH),
  localparam int ENT_BASE = 2 * DEPTH
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [IW-1:0]     slot,
  input  logic [DATA_W-1:0] brFrom,
  input  logic [DATA_W-1:0] brTo,
  input  logic [AW-1:0]     regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] cfgWord,
  output logic [DATA_W-1:0] regRdData
);
  logic [DATA_W-1:0] fromQ [DEPTH];
  logic [DATA_W-1:0] toQ   [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    localparam logic [AW-1:0] FROM_A = AW'(ENT_BASE + 2 * i);
    localparam logic [AW-1:0] TO_A   = AW'(ENT_BASE + 2 * i + 1);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        fromQ[i] <= '0;
        toQ[i]   <= '0;
      end else if (strobe.capture && slot == IW'(i)) begin
        fromQ[i] <= brFrom;
        toQ[i]   <= brTo;
      end else if (strobe.hostWrite && regAddr == FROM_A) begin
        fromQ[i] <= regWrData;
      end else if (strobe.hostWrite && regAddr == TO_A) begin
        toQ[i] <= regWrData;
      end
    end
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == '0) regRdData = cfgWord;
    for (int i = 0; i < DEPTH; i++) begin
      if (regAddr == AW'(ENT_BASE + 2 * i))     regRdData = fromQ[i];
      if (regAddr == AW'(ENT_BASE + 2 * i + 1)) regRdData = toQ[i];
    end
  end

  // R2: reserved pair reads as 11b through the read port
  a_r2_rsv_read: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == '0) |-> (regRdData[RSV_LSB +: 2] == 2'b11));
endmodule

// File: rtl/branch_sample_recorder.sv
module branch_sample_recorder
  import bsr_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 64,
  localparam int AW    = $clog2(4 * DEPTH),
  localparam int IW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              brTaken,
  input  logic [DATA_W-1:0] brFrom,
  input  logic [DATA_W-1:0] brTo,
  input  logic              ctrOverflow,
  input  logic [AW-1:0]     regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqOut
);
  dpStrobe_t         strobe;
  logic [IW-1:0]     slot;
  logic [DATA_W-1:0] cfgWord;

  bsr_ctrl #(.DEPTH(DEPTH), .AW(AW), .DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .brTaken(brTaken), .ctrOverflow(ctrOverflow),
    .regWrEn(regWrEn), .regAddr(regAddr),
    .wrEnable(regWrData[EN_BIT]), .wrValid(regWrData[VALID_BIT]),
    .wrIdx(regWrData[IDX_LSB +: IW]), .wrSel(regWrData[SEL_LSB +: SEL_W]),
    .strobe(strobe), .slot(slot), .cfgWord(cfgWord), .irqOut(irqOut)
  );

  bsr_datapath #(.DEPTH(DEPTH), .AW(AW), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .slot(slot),
    .brFrom(brFrom), .brTo(brTo), .regAddr(regAddr), .regWrData(regWrData),
    .cfgWord(cfgWord), .regRdData(regRdData)
  );
endmodule

// File: tb/branch_sample_recorder_tb_top.sv
module branch_sample_recorder_tb_top;
  localparam int DEPTH = 16, DW = 64, AW = 6, EB = 32;

  logic clk = 1'b0, rstN = 1'b0;
  always #10 clk = ~clk;

  logic brTaken = 0, ctrOverflow = 0, regWrEn = 0;
  logic [DW-1:0] brFrom = '0, brTo = '0, regWrData = '0;
  logic [AW-1:0] regAddr = '0;
  wire  [DW-1:0] regRdData;
  wire           irqOut;

  branch_sample_recorder dut_i (
    .clk(clk), .rstN(rstN), .brTaken(brTaken), .brFrom(brFrom), .brTo(brTo),
    .ctrOverflow(ctrOverflow), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .irqOut(irqOut)
  );

  // behavioural reference
  logic [DW-1:0] mFrom [DEPTH];
  logic [DW-1:0] mTo   [DEPTH];
  bit mEn, mValid, mArmed, mIrq, oldEn, held;
  int mIdx;
  logic [2:0] mSel;
  int total = 0, bad = 0;
  string curReq = "R1";
  bit checking = 0;

  function automatic logic [DW-1:0] expRead(input logic [AW-1:0] a);
    logic [DW-1:0] v = '0;
    if (a == 0) begin
      v[2] = mEn; v[4:3] = 2'b11; v[5] = mValid;
      v[19:16] = mIdx[3:0]; v[26:24] = mSel;
    end else if (a >= EB) begin
      v = a[0] ? mTo[(a - EB) / 2] : mFrom[(a - EB) / 2];
    end
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin mFrom[i] = '0; mTo[i] = '0; end
      mEn = 0; mValid = 0; mArmed = 0; mIrq = 0; mIdx = 0; mSel = '0;
    end else begin
      oldEn = mEn;
      held  = mArmed || (ctrOverflow && oldEn);
      if (mEn && mArmed && brTaken && !regWrEn) begin
        mFrom[mIdx] = brFrom; mTo[mIdx] = brTo; mValid = 1;
        if (mIdx == DEPTH - 1) begin mIdx = 0; mEn = 0; end
        else mIdx = mIdx + 1;
      end
      if (regWrEn) begin
        if (regAddr == 0) begin
          mEn = regWrData[2]; mValid = regWrData[5];
          mIdx = int'(regWrData[19:16]); mSel = regWrData[26:24];
        end else if (regAddr >= EB) begin
          if (regAddr[0]) mTo[(regAddr - EB) / 2] = regWrData;
          else            mFrom[(regAddr - EB) / 2] = regWrData;
        end
      end
      mIrq   = (ctrOverflow && !oldEn) || (held && !mEn);
      mArmed = held && mEn;
    end
  end

  always @(negedge clk) begin
    if (checking) begin
      logic [DW-1:0] e;
      e = expRead(regAddr);
      total++;
      if (regRdData !== e) begin
        bad++;
        $display("FAIL %s read addr=%0d actual=%h expected=%h", curReq, regAddr, regRdData, e);
      end
      total++;
      if (irqOut !== mIrq) begin
        bad++;
        $display("FAIL %s irq actual=%b expected=%b", curReq, irqOut, mIrq);
      end
    end
  end

  task automatic step(bit bt = 0, logic [DW-1:0] f = '0, logic [DW-1:0] t = '0,
                      bit ovf = 0, bit we = 0, logic [AW-1:0] a = '0,
                      logic [DW-1:0] wd = '0);
    @(negedge clk); #1;
    brTaken = bt; brFrom = f; brTo = t; ctrOverflow = ovf;
    regWrEn = we; regAddr = a; regWrData = wd;
  endtask

  function automatic logic [DW-1:0] cfgVal(bit en, bit vl, int idx, int sel);
    logic [DW-1:0] v = '0;
    v[2] = en; v[5] = vl; v[19:16] = idx[3:0]; v[26:24] = sel[2:0];
    return v;
  endfunction

  task automatic wrCfg(bit en, bit vl, int idx, int sel);
    step(.we(1), .a(0), .wd(cfgVal(en, vl, idx, sel)));
  endtask

  task automatic readAll();
    step(.a(0));
    for (int i = EB; i < 2 * EB; i++) step(.a(AW'(i)));
  endtask

  task automatic branch(int n, bit ovf = 0);
    for (int i = 0; i < n; i++)
      step(.bt(1), .f({32'h1000_0000, 32'(i * 16 + $urandom % 8)}),
           .t({32'hF000_0000, $urandom}), .ovf(ovf && i == 0));
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1; rstN = 1; checking = 1;
    curReq = "R1"; readAll();

    curReq = "R2";
    step(.we(1), .a(0), .wd('1));
    step(.a(0));
    step(.we(1), .a(0), .wd(64'h0000_0000_0000_0000));
    wrCfg(0, 1, 9, 5); step(.a(0));
    wrCfg(0, 0, 0, 0); step(.a(0));

    curReq = "R3";
    step(.we(1), .a(AW'(EB + 1)), .wd(64'hFFFF_FFFF_FFFF_FFFE));
    step(.we(1), .a(AW'(EB + 30)), .wd(64'h1234_5678_9ABC_DEF0));
    step(.we(1), .a(7), .wd(64'hDEAD));
    step(.a(7)); step(.a(AW'(EB + 1))); step(.a(AW'(EB + 30)));

    curReq = "R5";
    branch(3);
    wrCfg(1, 0, 0, 2);
    branch(3);
    step(.a(0)); step(.a(AW'(EB)));

    curReq = "R4";
    step(.ovf(1));
    branch(4);
    step(.a(0)); step(.a(AW'(EB))); step(.a(AW'(EB + 7)));

    curReq = "R11";
    step(.bt(1), .f(64'hAA), .t(64'hBB), .we(1), .a(AW'(EB + 20)), .wd(64'h55));
    step(.a(0)); step(.a(AW'(EB + 20)));

    curReq = "R6";
    branch(12);
    step(.a(0));
    branch(5);
    readAll();

    curReq = "R8";
    wrCfg(1, 0, 0, 1);
    branch(2);
    step(.ovf(1));
    step(); step();
    branch(16);
    step(); step(.a(0));

    curReq = "R7";
    wrCfg(1, 0, 10, 3);
    step(.ovf(1));
    branch(6);
    step(); step(.a(0)); readAll();

    curReq = "R9";
    wrCfg(1, 0, 4, 0);
    step(.ovf(1));
    branch(3);
    wrCfg(0, 1, 7, 0);
    step(.a(0)); step();
    wrCfg(1, 1, 7, 0);
    step(.ovf(1), .we(1), .a(0), .wd(cfgVal(0, 1, 7, 0)));
    step(.a(0));

    curReq = "R10";
    step(.ovf(1)); step(); branch(2); step(.a(0));

    curReq = "R12";
    wrCfg(1, 0, 0, 0);
    step(.ovf(1)); branch(1); step(.a(0));
    wrCfg(0, 1, 1, 0); step(.a(0));
    wrCfg(0, 0, 0, 0); step(.a(0));

    curReq = "R4";
    for (int n = 0; n < 3000; n++) begin
      bit we = ($urandom % 12) == 0;
      logic [AW-1:0] a = AW'($urandom);
      logic [DW-1:0] wd = {$urandom, $urandom};
      if (we && ($urandom % 2)) a = 0;
      step(.bt(1'($urandom)), .f({$urandom, $urandom}), .t({$urandom, $urandom}),
           .ovf(($urandom % 10) == 0), .we(we), .a(a), .wd(wd));
    end
    readAll();

    summary();
    $finish;
  end
endmodule